// File: doc/BRIEF.md
# Subtract-with-Borrow Arithmetic Unit

This unit takes an accumulator byte, an operand byte and an incoming carry bit, and subtracts both the operand and the carry from the accumulator. The 8-bit difference becomes the new accumulator value. At the same time the unit builds a byte of condition flags that describes the result: sign, zero, borrow out of the low nibble, signed overflow, a subtract marker and the full borrow.

Both the new accumulator and the flag byte are held in registers. They load only when the execute strobe is high. A surrounding datapath supplies the operand, which may come from a register or from memory, and it supplies the current carry. The datapath raises the strobe for one clock per operation and reads the registered outputs after that edge. The subtraction is built as a chain of nibble-wide borrow slices. The borrow between slices is where the nibble flag comes from, and comparing the borrow into the top bit with the borrow out of it gives the overflow.

Top module: `sbc_alu`

## Requirements
- R1: On a clock edge with `exec_i` high and `rst` low, `acc_o` loads (`acc_i` − `opnd_i` − `cy_i`) modulo 256.
- R2: After an execute, flag bit 7 (sign) equals bit 7 of the new `acc_o`.
- R3: After an execute, flag bit 6 (zero) is 1 exactly when the new `acc_o` is 0x00.
- R4: After an execute, flag bit 4 (nibble borrow) is 1 exactly when `acc_i[3:0]` < `opnd_i[3:0]` + `cy_i`.
- R5: After an execute, flag bit 2 (overflow) is 1 exactly when `acc_i` and `opnd_i` have different bit 7 and the result's bit 7 differs from bit 7 of `acc_i`.
- R6: After an execute, flag bit 1 (subtract marker) is 1.
- R7: After an execute, flag bit 0 (borrow) is 1 exactly when `acc_i` < `opnd_i` + `cy_i` as unsigned values.
- R8: Flag bits 5 and 3 are always 0.
- R9: On a clock edge with `exec_i` low, `acc_o` and `flags_o` keep their values, whatever `acc_i`, `opnd_i` and `cy_i` carry.
- R10: On a clock edge with `rst` high, `acc_o` and `flags_o` both become 0x00, even when `exec_i` is high on that edge.
- R11: With `acc_i` = 0x00, `opnd_i` = 0x00 and `cy_i` = 1, an execute gives `acc_o` = 0xFF and `flags_o` = 0x93 (sign, nibble borrow, subtract marker and borrow set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the registers load on the rising edge |
| rst | input | 1 | Synchronous reset, active high; takes priority over execute |
| exec_i | input | 1 | Execute strobe; loads the result and the flags |
| acc_i | input | 8 | Current accumulator value (minuend) |
| opnd_i | input | 8 | Operand byte (subtrahend) |
| cy_i | input | 1 | Incoming carry, subtracted as an extra borrow |
| acc_o | output | 8 | Registered difference |
| flags_o | output | 8 | Registered flags: bit 7 sign, 6 zero, 4 nibble borrow, 2 overflow, 1 subtract marker, 0 borrow; bits 5 and 3 are zero |

## Verification
The synchronous reset and the execute strobe can both be high on the same edge. Each of them would load different values into the same two registers. The bench sets up a non-zero result first, then raises `rst` while `exec_i` is still high with inputs that would give a non-zero difference. It then requires both outputs to be 0x00 after that edge. A table of hand-worked vectors and an exhaustive sweep over all 131072 operand, accumulator and carry combinations check every flag against wide-integer arithmetic in the bench. A hold step with changed inputs and the strobe low shows that the registers ignore their inputs when idle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int FLAG_W = 8;

  // Flag byte, most significant field first.
  typedef struct packed {
    logic sign;     // bit 7
    logic zero;     // bit 6
    logic rsv5;     // bit 5, tied low
    logic half;     // bit 4, nibble borrow
    logic rsv3;     // bit 3, tied low
    logic ovf;      // bit 2, signed overflow
    logic subn;     // bit 1, subtract marker
    logic borrow;   // bit 0, full borrow
  } sbc_flags_t;

  localparam int FB_SIGN   = 7;
  localparam int FB_ZERO   = 6;
  localparam int FB_RSV5   = 5;
  localparam int FB_HALF   = 4;
  localparam int FB_RSV3   = 3;
  localparam int FB_OVF    = 2;
  localparam int FB_SUBN   = 1;
  localparam int FB_BORROW = 0;

endpackage

// File: rtl/sbc_slice.sv
module sbc_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         bin_i,
  output logic [W-1:0] diff_o,
  output logic         bout_o
);

  // One extra bit on top catches the borrow out of this slice.
  function automatic logic [W:0] slice_sub(input logic [W-1:0] a,
                                           input logic [W-1:0] b,
                                           input logic         bin);
    return {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin};
  endfunction

  logic [W:0] wide;

  always_comb begin
    wide   = slice_sub(a_i, b_i, bin_i);
    diff_o = wide[W-1:0];
    bout_o = wide[W];
  end

endmodule

// File: rtl/sbc_borrow_chain.sv
module sbc_borrow_chain #(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              bin_i,
  output logic [DATA_W-1:0] diff_o,
  output logic              half_borrow_o,
  output logic              full_borrow_o,
  output logic              msb_borrow_in_o
);

  localparam int NSL = DATA_W / SLICE_W;

  logic [NSL:0] bchain;

  assign bchain[0] = bin_i;

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    sbc_slice #(.W(SLICE_W)) u_slice (
      .a_i    (a_i[g*SLICE_W +: SLICE_W]),
      .b_i    (b_i[g*SLICE_W +: SLICE_W]),
      .bin_i  (bchain[g]),
      .diff_o (diff_o[g*SLICE_W +: SLICE_W]),
      .bout_o (bchain[g+1])
    );
  end

  // Borrow arriving at the top bit, from the bits below it alone.
  function automatic logic low_borrow(input logic [DATA_W-1:0] a,
                                      input logic [DATA_W-1:0] b,
                                      input logic              bin);
    logic [DATA_W-1:0] t;
    t = {1'b0, a[DATA_W-2:0]} - {1'b0, b[DATA_W-2:0]}
        - {{(DATA_W-1){1'b0}}, bin};
    return t[DATA_W-1];
  endfunction

  assign half_borrow_o   = bchain[1];
  assign full_borrow_o   = bchain[NSL];
  assign msb_borrow_in_o = low_borrow(a_i, b_i, bin_i);

endmodule

// File: rtl/sbc_flag_gen.sv
module sbc_flag_gen
  import sbc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] diff_i,
  input  logic              half_borrow_i,
  input  logic              full_borrow_i,
  input  logic              msb_borrow_in_i,
  output sbc_flags_t        flags_o
);

  always_comb begin
    flags_o        = '0;
    flags_o.sign   = diff_i[DATA_W-1];
    flags_o.zero   = ~|diff_i;
    flags_o.half   = half_borrow_i;
    flags_o.ovf    = full_borrow_i ^ msb_borrow_in_i;
    flags_o.subn   = 1'b1;
    flags_o.borrow = full_borrow_i;
  end

endmodule

// File: rtl/sbc_state_reg.sv
module sbc_state_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

endmodule

// File: rtl/sbc_alu.sv
module sbc_alu
  import sbc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SLICE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] acc_o,
  output logic [FLAG_W-1:0] flags_o
);

  logic [DATA_W-1:0] next_acc;
  logic              half_borrow;
  logic              full_borrow;
  logic              msb_borrow_in;
  sbc_flags_t        next_flags;

  sbc_borrow_chain #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chain (
    .a_i             (acc_i),
    .b_i             (opnd_i),
    .bin_i           (cy_i),
    .diff_o          (next_acc),
    .half_borrow_o   (half_borrow),
    .full_borrow_o   (full_borrow),
    .msb_borrow_in_o (msb_borrow_in)
  );

  sbc_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .diff_i          (next_acc),
    .half_borrow_i   (half_borrow),
    .full_borrow_i   (full_borrow),
    .msb_borrow_in_i (msb_borrow_in),
    .flags_o         (next_flags)
  );

  sbc_state_reg #(.W(DATA_W)) u_acc_reg (
    .clk  (clk),
    .rst  (rst),
    .en_i (exec_i),
    .d_i  (next_acc),
    .q_o  (acc_o)
  );

  sbc_state_reg #(.W(FLAG_W)) u_flag_reg (
    .clk  (clk),
    .rst  (rst),
    .en_i (exec_i),
    .d_i  (next_flags),
    .q_o  (flags_o)
  );

  // Registered outputs checked against the inputs of the previous edge.
  AST_RESULT_WRITE: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> acc_o == DATA_W'($past(acc_i) - $past(opnd_i)
                                - {{(DATA_W-1){1'b0}}, $past(cy_i)})); // R1
  AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> flags_o[FB_SIGN] == acc_o[DATA_W-1]); // R2
  AST_ZERO_DETECT: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> flags_o[FB_ZERO] == (acc_o == '0)); // R3
  AST_HALF_BORROW: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> flags_o[FB_HALF] ==
      ({1'b0, $past(acc_i[SLICE_W-1:0])} <
       ({1'b0, $past(opnd_i[SLICE_W-1:0])} + {{SLICE_W{1'b0}}, $past(cy_i)}))); // R4
  AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> flags_o[FB_OVF] ==
      (($past(acc_i[DATA_W-1]) != $past(opnd_i[DATA_W-1])) &&
       (acc_o[DATA_W-1] != $past(acc_i[DATA_W-1])))); // R5
  AST_SUB_MARK: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> flags_o[FB_SUBN]); // R6
  AST_FULL_BORROW: assert property (@(posedge clk) disable iff (rst)
    exec_i |=> flags_o[FB_BORROW] ==
      ({1'b0, $past(acc_i)} <
       ({1'b0, $past(opnd_i)} + {{DATA_W{1'b0}}, $past(cy_i)}))); // R7
  AST_RSV_LOW: assert property (@(posedge clk) disable iff (rst)
    !flags_o[FB_RSV5] && !flags_o[FB_RSV3]); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !exec_i |=> $stable(acc_o) && $stable(flags_o)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> acc_o == '0 && flags_o == '0); // R10

endmodule

// File: tb/test_sbc_alu.sv
`timescale 1ns/1ps
module test_sbc_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       exec_i = 1'b0;
  logic [7:0] acc_i = '0;
  logic [7:0] opnd_i = '0;
  logic       cy_i = 1'b0;
  logic [7:0] acc_o;
  logic [7:0] flags_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sbc_alu i_sbc_alu (
    .clk     (clk),
    .rst     (rst),
    .exec_i  (exec_i),
    .acc_i   (acc_i),
    .opnd_i  (opnd_i),
    .cy_i    (cy_i),
    .acc_o   (acc_o),
    .flags_o (flags_o)
  );

  // {acc, operand, carry, expected result, expected flags}
  localparam int NV = 10;
  localparam logic [32:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b1, 8'hFF, 8'h93},
    {8'h00, 8'h00, 1'b0, 8'h00, 8'h42},
    {8'h80, 8'h01, 1'b0, 8'h7F, 8'h16},
    {8'h7F, 8'hFF, 1'b0, 8'h80, 8'h87},
    {8'h10, 8'h0F, 1'b1, 8'h00, 8'h52},
    {8'h55, 8'h22, 1'b0, 8'h33, 8'h02},
    {8'h55, 8'h55, 1'b1, 8'hFF, 8'h93},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 8'h93},
    {8'h80, 8'h00, 1'b1, 8'h7F, 8'h16},
    {8'h3A, 8'h1C, 1'b0, 8'h1E, 8'h12}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] e_res;
    logic       e_s, e_z, e_h, e_v, e_c;
    logic [7:0] hold_acc, hold_flg;

    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset acc", acc_o, 8'h00);
    chk("R10 reset flags", flags_o, 8'h00);

    // Hand-worked vectors; the first one is the all-zero corner with carry.
    for (int v = 0; v < NV; v++) begin
      acc_i  = VEC[v][32:25];
      opnd_i = VEC[v][24:17];
      cy_i   = VEC[v][16];
      exec_i = 1'b1;
      @(negedge clk);
      exec_i = 1'b0;
      chk(v == 0 ? "R11 corner result" : "R1 table result", acc_o, VEC[v][15:8]);
      chk(v == 0 ? "R11 corner flags" : "R2 to R7 table flags", flags_o, VEC[v][7:0]);
    end

    // Idle strobe with new inputs must leave the registers unchanged.
    hold_acc = acc_o;
    hold_flg = flags_o;
    acc_i  = 8'h01;
    opnd_i = 8'h02;
    cy_i   = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 hold acc", acc_o, hold_acc);
    chk("R9 hold flags", flags_o, hold_flg);

    // Reset and execute on the same edge: reset must win.
    exec_i = 1'b1;
    rst    = 1'b1;
    @(negedge clk);
    rst    = 1'b0;
    exec_i = 1'b0;
    chk("R10 reset over exec acc", acc_o, 8'h00);
    chk("R10 reset over exec flags", flags_o, 8'h00);

    // Exhaustive sweep, pipelined: check previous, drive next.
    e_res = '0; e_s = 0; e_z = 0; e_h = 0; e_v = 0; e_c = 0;
    for (int i = 0; i <= 131072; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R1 result", acc_o, e_res);
        chk("R2 sign", {7'b0, flags_o[7]}, {7'b0, e_s});
        chk("R3 zero", {7'b0, flags_o[6]}, {7'b0, e_z});
        chk("R4 nibble borrow", {7'b0, flags_o[4]}, {7'b0, e_h});
        chk("R5 overflow", {7'b0, flags_o[2]}, {7'b0, e_v});
        chk("R6 subtract mark", {7'b0, flags_o[1]}, 8'h01);
        chk("R7 borrow", {7'b0, flags_o[0]}, {7'b0, e_c});
        chk("R8 unused bits", {6'b0, flags_o[5], flags_o[3]}, 8'h00);
      end
      if (i < 131072) begin
        int d, hd, sd;
        acc_i  = i[7:0];
        opnd_i = i[15:8];
        cy_i   = i[16];
        exec_i = 1'b1;
        d     = int'(acc_i) - int'(opnd_i) - int'(cy_i);
        hd    = int'(acc_i[3:0]) - int'(opnd_i[3:0]) - int'(cy_i);
        sd    = int'($signed(acc_i)) - int'($signed(opnd_i)) - int'(cy_i);
        e_res = 8'(d & 255);
        e_s   = e_res[7];
        e_z   = (e_res == 8'h00);
        e_h   = (hd < 0);
        e_v   = (sd > 127) || (sd < -128);
        e_c   = (d < 0);
      end else begin
        exec_i = 1'b0;
      end
    end

    finish_run();
  end

endmodule